// File: doc/BRIEF.md
# Status Register and Write-Protect Controller for a Serial EEPROM

This block keeps the protection state of a small serial EEPROM. It holds the write-enable latch, a two-bit protection level, a bit that arms the hardware protect pin, and a busy flag driven by a self-timed write cycle. The serial command engine sends it one-cycle strobes when a command completes: latch set, latch clear, status write (with its data byte), and array write (with its start address). The block answers each write request with a one-cycle grant. A grant means a write cycle of fixed length has begun.

The protection level covers an aligned region at the top of the array. That region is the upper quarter, the upper half, or the whole array. The level is computed from the two top address bits, so it scales with the array-size parameter. The protect pin is active low. It acts only while the arm bit is set, and it then locks the status register, while unprotected array regions stay writable. During a write cycle, the status byte returned to the reader is all ones and every other command is ignored.

Top module: `eeprom_prot_ctrl`

## Requirements
- R1: After reset, the status byte is 0x00, busy is low, and both grants are low. Reset also clears the latch, the arm bit and the protection level.
- R2: When no write cycle is running, status bits 6..4 read 0 and bit 0 reads 0.
- R3: While a write cycle runs, the status byte reads 0xFF.
- R4: A latch-set strobe on an idle block sets the latch, and status bit 1 then reads 1.
- R5: A latch-clear strobe on an idle block clears the latch, whatever the level of the protect pin.
- R6: Let T be the two top address bits. Level 00 protects nothing. Level 01 protects T=11. Level 10 protects T=1x. Level 11 protects every address. An array write to a protected address is never granted.
- R7: When the arm bit is 1 and the protect pin is low, a status write is refused. An array write to an unprotected address is still granted if the latch is set.
- R8: With the latch clear, no array write and no status write is granted.
- R9: Once a write cycle has begun, busy stays high for its full length, even if the protect pin falls during the cycle.
- R10: busy rises together with a grant and stays high for exactly WR_CYCLES clock cycles. It falls in the same cycle that the latch clears.
- R11: A refused array write or status write starts no cycle and clears the latch.
- R12: While busy, latch, status-write and array-write strobes are ignored: no grant, and the protection state does not change.
- R13: A granted status write loads the arm bit from data bit 7 and the protection level from data bits 3:2. The status byte places them at bit 7 and bits 3:2, with the latch at bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Hardware protect pin, active low |
| set_wel | input | 1 | Latch-set strobe |
| clr_wel | input | 1 | Latch-clear strobe |
| sr_wr | input | 1 | Status-write request strobe |
| sr_wdata | input | 8 | Status-write data byte |
| arr_wr | input | 1 | Array-write request strobe |
| arr_addr | input | ADDR_W | Array-write start address |
| status_q | output | 8 | Registered status byte |
| busy | output | 1 | Write cycle in progress |
| arr_grant | output | 1 | Array write accepted, one-cycle pulse |
| sr_grant | output | 1 | Status write accepted, one-cycle pulse |

## Verification
The bench builds the block with a 10-bit address and a 12-cycle write time. With the short write time, hundreds of write cycles fit in a short run, and so do commands injected in the middle of a cycle. With the 10-bit address, the protection boundaries fall at 0x200 and 0x300, so directed probes just below and at each boundary check the region decode exactly. Random commands, protect-pin levels, data and addresses then exercise the combinations of latch, arm bit and pin.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_lvl_e;

  localparam int unsigned SR_ARM_BIT  = 7;
  localparam int unsigned SR_LVL_HI   = 3;
  localparam int unsigned SR_LVL_LO   = 2;
  localparam logic [7:0]  SR_BUSY_VAL = 8'hFF;
endpackage

// File: rtl/prot_window.sv
module prot_window
  import eepc_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  prot_lvl_e           lvl,
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit
);
  localparam int unsigned TOP = ADDR_W - 1;

  logic [1:0] top2;
  assign top2 = addr[TOP -: 2];

  always_comb begin
    unique case (lvl)
      PROT_NONE:    hit = 1'b0;
      PROT_QUARTER: hit = (top2 == 2'b11);
      PROT_HALF:    hit = top2[1];
      default:      hit = 1'b1;
    endcase
  end

  initial begin
    assert (ADDR_W >= 2) else $error("ADDR_W must be at least 2");
  end
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int unsigned CYCLES = 40000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R9: a running cycle is never cut short
  p_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  // R10: a counted cycle ends when the count runs out
  p_end_on_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/eeprom_prot_ctrl.sv
module eeprom_prot_ctrl
  import eepc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned WR_CYCLES = 40000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n,
  input  logic              set_wel,
  input  logic              clr_wel,
  input  logic              sr_wr,
  input  logic [7:0]        sr_wdata,
  input  logic              arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        status_q,
  output logic              busy,
  output logic              arr_grant,
  output logic              sr_grant
);
  logic      wel_q;
  logic      arm_q;
  prot_lvl_e lvl_q;
  logic      blk_hit;
  logic      cyc_done;
  logic      hw_lock;
  logic      take_sr;
  logic      take_arr;
  logic      start;
  logic      idle;

  prot_window #(.ADDR_W(ADDR_W)) u_win (
    .lvl  (lvl_q),
    .addr (arr_addr),
    .hit  (blk_hit)
  );

  cycle_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (cyc_done)
  );

  assign idle     = !busy;
  assign hw_lock  = arm_q && !wp_n;
  assign take_sr  = idle && sr_wr && wel_q && !hw_lock;
  assign take_arr = idle && arr_wr && !sr_wr && wel_q && !blk_hit;
  assign start    = take_sr || take_arr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q     <= 1'b0;
      arm_q     <= 1'b0;
      lvl_q     <= PROT_NONE;
      arr_grant <= 1'b0;
      sr_grant  <= 1'b0;
      status_q  <= 8'h00;
    end else begin
      arr_grant <= take_arr;
      sr_grant  <= take_sr;
      if (cyc_done) begin
        wel_q <= 1'b0;
      end else if (idle) begin
        if (sr_wr || arr_wr) begin
          if (!start) wel_q <= 1'b0;
        end else if (clr_wel) begin
          wel_q <= 1'b0;
        end else if (set_wel) begin
          wel_q <= 1'b1;
        end
      end
      if (take_sr) begin
        arm_q <= sr_wdata[SR_ARM_BIT];
        lvl_q <= prot_lvl_e'(sr_wdata[SR_LVL_HI:SR_LVL_LO]);
      end
      status_q <= busy ? SR_BUSY_VAL : {arm_q, 3'b000, lvl_q, wel_q, 1'b0};
    end
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_q == 8'h00 && !busy && !arr_grant && !sr_grant));

  p_idle_bits_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> (status_q[6:4] == 3'b000 && !status_q[0]));

  p_busy_ones_r3: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> (status_q == 8'hFF));

  p_wel_set_r4: assert property (@(posedge clk) disable iff (rst)
    (idle && set_wel && !clr_wel && !sr_wr && !arr_wr) |=> wel_q);

  p_wel_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (idle && clr_wel && !sr_wr && !arr_wr) |=> !wel_q);

  p_block_region_r6: assert property (@(posedge clk) disable iff (rst)
    arr_grant |-> !$past(blk_hit));

  p_hw_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (sr_wr && arm_q && !wp_n) |=> !sr_grant);

  p_need_wel_r8: assert property (@(posedge clk) disable iff (rst)
    !wel_q |=> (!arr_grant && !sr_grant));

  p_grant_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (arr_grant || sr_grant) |-> busy);

  p_end_clears_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel_q);

  p_deny_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (idle && (sr_wr || arr_wr) && !start) |=> (!wel_q && !busy));

  p_ignore_busy_r12: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(arm_q) && $stable(lvl_q) && !arr_grant && !sr_grant));

  p_sr_load_r13: assert property (@(posedge clk) disable iff (rst)
    sr_grant |-> (arm_q == $past(sr_wdata[7]) && lvl_q == $past(sr_wdata[3:2])));
endmodule

// File: tb/eeprom_prot_ctrl_tb.sv
module eeprom_prot_ctrl_tb;
  localparam int unsigned AW = 10;
  localparam int unsigned WR = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wp_n = 1'b1;
  logic          set_wel = 1'b0, clr_wel = 1'b0, sr_wr = 1'b0, arr_wr = 1'b0;
  logic [7:0]    sr_wdata = 8'h00;
  logic [AW-1:0] arr_addr = '0;
  logic [7:0]    status_q;
  logic          busy, arr_grant, sr_grant;

  int checks = 0;
  int errors = 0;

  logic       m_wel = 1'b0;
  logic       m_arm = 1'b0;
  logic [1:0] m_lvl = 2'b00;

  eeprom_prot_ctrl #(.ADDR_W(AW), .WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst(rst), .wp_n(wp_n), .set_wel(set_wel), .clr_wel(clr_wel),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .arr_wr(arr_wr), .arr_addr(arr_addr),
    .status_q(status_q), .busy(busy), .arr_grant(arr_grant), .sr_grant(sr_grant)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {m_arm, 3'b000, m_lvl, m_wel, 1'b0};
  endfunction

  function automatic logic region_hit(logic [AW-1:0] a);
    logic [1:0] t;
    t = a[AW-1 -: 2];
    case (m_lvl)
      2'b00:   return 1'b0;
      2'b01:   return t == 2'b11;
      2'b10:   return t[1];
      default: return 1'b1;
    endcase
  endfunction

  task automatic drive(int kind, logic [7:0] d, logic [AW-1:0] a);
    set_wel  = (kind == 0);
    clr_wel  = (kind == 1);
    sr_wr    = (kind == 2);
    arr_wr   = (kind == 3);
    sr_wdata = d;
    arr_addr = a;
  endtask

  // kind: 0 latch set, 1 latch clear, 2 status write, 3 array write
  task automatic do_cmd(int kind, logic [7:0] d, logic [AW-1:0] a, logic wp_mid, string tag);
    logic g_sr, g_arr, wp_keep;
    g_sr  = (kind == 2) && m_wel && !(m_arm && !wp_n);
    g_arr = (kind == 3) && m_wel && !region_hit(a);
    drive(kind, d, a);
    tick();
    drive(-1, 8'h00, '0);
    chk({tag, " grant"}, {6'b0, sr_grant, arr_grant}, {6'b0, g_sr, g_arr});
    if (kind == 0) m_wel = 1'b1;
    if (kind == 1) m_wel = 1'b0;
    if (g_sr) begin
      m_arm = d[7];
      m_lvl = d[3:2];
    end
    if (g_sr || g_arr) begin
      chk("R10 busy at grant", {7'b0, busy}, 8'h01);
      wp_keep = wp_n;
      wp_n = wp_mid;
      drive(int'($urandom % 4), 8'($urandom), AW'($urandom));
      tick();
      drive(-1, 8'h00, '0);
      chk("R12 no grant while busy", {6'b0, sr_grant, arr_grant}, 8'h00);
      chk("R3 status all ones", status_q, 8'hFF);
      repeat (WR - 2) tick();
      chk("R9 busy held to end", {7'b0, busy}, 8'h01);
      tick();
      chk("R10 busy ends after WR cycles", {7'b0, busy}, 8'h00);
      wp_n = wp_keep;
      m_wel = 1'b0;
    end else if (kind >= 2) begin
      m_wel = 1'b0;
    end
    tick();
    chk({tag, " status"}, status_q, exp_status());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 reset status", status_q, 8'h00);
    chk("R1 reset outputs", {5'b0, busy, arr_grant, sr_grant}, 8'h00);

    do_cmd(3, 8'h00, 10'h000, 1'b1, "R8 array no latch");
    do_cmd(2, 8'h8C, 10'h000, 1'b1, "R8 status no latch");
    do_cmd(0, 8'h00, 10'h000, 1'b1, "R4 latch set");
    do_cmd(1, 8'h00, 10'h000, 1'b1, "R5 latch clear");
    do_cmd(0, 8'h00, 10'h000, 1'b1, "R4 latch set again");
    wp_n = 1'b0;
    do_cmd(1, 8'h00, 10'h000, 1'b1, "R5 clear with pin low");
    wp_n = 1'b1;
    do_cmd(0, 8'h00, 10'h000, 1'b1, "R4 set");
    do_cmd(2, 8'h8C, 10'h000, 1'b1, "R13 status load");
    wp_n = 1'b0;
    do_cmd(0, 8'h00, 10'h000, 1'b0, "R4 set");
    do_cmd(2, 8'h00, 10'h000, 1'b0, "R7 status locked");
    do_cmd(0, 8'h00, 10'h000, 1'b0, "R4 set");
    do_cmd(3, 8'h00, 10'h000, 1'b0, "R6 all protected");
    wp_n = 1'b1;
    do_cmd(0, 8'h00, 10'h000, 1'b1, "R4 set");
    do_cmd(2, 8'h84, 10'h000, 1'b1, "R13 quarter");
    wp_n = 1'b0;
    do_cmd(0, 8'h00, 10'h000, 1'b0, "R4 set");
    do_cmd(3, 8'h00, 10'h2FF, 1'b0, "R7 array open under lock");
    do_cmd(0, 8'h00, 10'h000, 1'b0, "R4 set");
    do_cmd(3, 8'h00, 10'h300, 1'b0, "R6 quarter edge");
    wp_n = 1'b1;
    do_cmd(0, 8'h00, 10'h000, 1'b1, "R4 set");
    do_cmd(2, 8'h88, 10'h000, 1'b1, "R13 half");
    do_cmd(0, 8'h00, 10'h000, 1'b1, "R4 set");
    do_cmd(3, 8'h00, 10'h1FF, 1'b1, "R6 below half");
    do_cmd(0, 8'h00, 10'h000, 1'b1, "R4 set");
    do_cmd(3, 8'h00, 10'h200, 1'b1, "R6 half edge");
    do_cmd(2, 8'h00, 10'h000, 1'b1, "R11 denied clears");
    do_cmd(0, 8'h00, 10'h000, 1'b1, "R4 set");
    do_cmd(2, 8'h70, 10'h000, 1'b1, "R2 unused bits dropped");
    do_cmd(0, 8'h00, 10'h000, 1'b1, "R4 set");
    do_cmd(3, 8'h00, 10'h3FF, 1'b1, "R6 none protected");
    do_cmd(0, 8'h00, 10'h000, 1'b1, "R4 set");
    do_cmd(2, 8'h80, 10'h000, 1'b0, "R9 pin falls mid cycle");

    for (int i = 0; i < 300; i++) begin
      wp_n = 1'($urandom);
      do_cmd(int'($urandom % 4), 8'($urandom), AW'($urandom), 1'($urandom), "R6 R7 R11 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule